// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block sits between the core of a small 8-bit microcontroller and its external memory pins. Program space and data space are kept apart, each 64K by 8 bits. The core presents one request at a time. A request carries a space select (program or data), a write flag, a 16-bit address and, for writes, a data byte. The block then runs a fixed sequence of bus phases. A single 8-bit shared port first carries the low address byte, which the board latches on an address-latch pulse. The same port then carries the data byte. A second port holds the high address byte for the whole access. The block generates active-low strobes: a program-read strobe for program fetches, and separate read and write strobes for data memory.

The shared port is given to the pad ring as three signals: an output byte, an output enable and an input byte. The tri-state buffer itself lives in the pad. When an access finishes, the block raises `rsp_done` for one cycle. For reads, the captured byte is on `rsp_rdata` at that point. A new request is taken only while `req_ready` is high, which happens only in the idle state.

The sequencer has five states:
- IDLE: waiting; `req_ready` is high.
- ADDR: held for `ADDR_CYC` cycles. The port drives the low address byte. The latch pulse is high in every ADDR cycle except the last.
- FLOAT: one cycle, used by reads only. The port is released here.
- STROBE: held for `STB_CYC` cycles. One strobe is low.
- SAMPLE: one cycle; `rsp_done` is high.

The transitions are:
- IDLE→ADDR when a request is accepted.
- ADDR→FLOAT for a read at the end of the address phase.
- ADDR→STROBE for a write at the end of the address phase.
- FLOAT→STROBE after its single cycle.
- STROBE→SAMPLE after the last strobe cycle.
- SAMPLE→IDLE.

Top module: `mux_membus`

## Requirements
- R1: While reset is held and right after it, `req_ready`=1, `bus_ale`=0, all three strobes are 1, `bus_ad_oe`=0, `bus_addr_hi`=0, `rsp_done`=0 and `rsp_rdata`=0.
- R2: The address phase lasts `ADDR_CYC` cycles from the accepting edge, with `bus_ad_oe`=1 and `bus_ad_out` equal to the low address byte. `bus_ale` is 1 for the first `ADDR_CYC`-1 of those cycles. It falls while the port still drives the address for one more cycle.
- R3: `bus_addr_hi` equals the high address byte from the cycle after acceptance through the done cycle, for both spaces. It is 0 in IDLE.
- R4: With `req_space`=0 (program), `bus_prog_rd_n` is low for exactly `STB_CYC` cycles and the data strobes stay high. `req_write` is ignored in program space: the access is still a fetch.
- R5: With `req_space`=1 and `req_write`=0, `bus_data_rd_n` is low for exactly `STB_CYC` cycles and the other strobes stay high.
- R6: With `req_space`=1 and `req_write`=1, `bus_data_wr_n` is low for `STB_CYC` cycles. Throughout that window and the done cycle, `bus_ad_oe`=1 and `bus_ad_out` holds the write byte.
- R7: On any read, `bus_ad_oe` is 0 for at least one full cycle before the read strobe falls. It stays 0 while the strobe is low.
- R8: Read data is taken from `bus_ad_in` on the clock edge that ends the read strobe. It is shown on `rsp_rdata` from the done cycle, and it holds until the next read completes; writes leave it unchanged.
- R9: `rsp_done` is a one-cycle pulse. On the `ADDR_CYC`+`STB_CYC`+1-th edge after the accepting edge for reads, and on the `ADDR_CYC`+`STB_CYC`-th edge for writes, it becomes 1.
- R10: `req_ready` is 1 only in IDLE. A `req_valid` raised while busy and dropped before IDLE starts no access.
- R11: At most one strobe is low at any time, and no strobe is low while `bus_ale` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Sequencer idle; request taken on this edge |
| req_space | input | 1 | 0 = program space, 1 = data space |
| req_write | input | 1 | Write flag (data space only) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last read byte |
| bus_ad_out | output | 8 | Shared port output byte (address low, then write data) |
| bus_ad_oe | output | 1 | Shared port output enable |
| bus_ad_in | input | 8 | Shared port input byte |
| bus_addr_hi | output | 8 | High address byte |
| bus_ale | output | 1 | Address latch pulse, active high |
| bus_prog_rd_n | output | 1 | Program read strobe, active low |
| bus_data_rd_n | output | 1 | Data read strobe, active low |
| bus_data_wr_n | output | 1 | Data write strobe, active low |

## Verification
Outside the read strobe, the bench memory model drives a junk byte on the input port. A design that captured a cycle late, in SAMPLE, would therefore return that junk instead of the addressed byte. The bench also looks for bus contention. It checks that the port is undriven in the cycle before and throughout each read strobe, and that the address is still driven in the cycle after the latch pulse falls; a design that turned the port early or dropped the latch late would fail these. A program request with the write flag set must still produce a fetch and not a write. A request raised mid-access must not start a hidden second cycle, which would show up as an unmatched latch pulse and done.

// File: rtl/mux_membus_pkg.sv
package mux_membus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_FLOAT  = 3'd2,
        ST_STROBE = 3'd3,
        ST_SAMPLE = 3'd4
    } phase_e;

    typedef enum logic {
        SP_PROG = 1'b0,
        SP_DATA = 1'b1
    } space_e;

endpackage

// File: rtl/mux_membus_seq.sv
module mux_membus_seq
    import mux_membus_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int ADDR_CYC = 2,
    parameter int STB_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_space,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output phase_e            phase,
    output logic              phase_end,
    output space_e            cur_space,
    output logic              cur_read,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata
);

    localparam int CNT_MAX = (ADDR_CYC > STB_CYC) ? ADDR_CYC : STB_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX) + 1;
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_CYC - 1);
    localparam logic [CNT_W-1:0] STB_LAST  = CNT_W'(STB_CYC - 1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept;

    assign accept    = (phase_q == ST_IDLE) && req_valid;
    assign phase_end = ((phase_q == ST_ADDR)   && (cnt_q == ADDR_LAST)) ||
                       ((phase_q == ST_STROBE) && (cnt_q == STB_LAST));
    assign phase     = phase_q;

    // next-state and phase counter
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            ST_IDLE: begin
                if (req_valid) begin
                    phase_d = ST_ADDR;
                    cnt_d   = '0;
                end
            end
            ST_ADDR: begin
                if (phase_end) begin
                    phase_d = cur_read ? ST_FLOAT : ST_STROBE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_FLOAT: begin
                phase_d = ST_STROBE;
                cnt_d   = '0;
            end
            ST_STROBE: begin
                if (phase_end) begin
                    phase_d = ST_SAMPLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SAMPLE: begin
                phase_d = ST_IDLE;
            end
            default: begin
                phase_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= ST_IDLE;
            cnt_q     <= '0;
            cur_space <= SP_PROG;
            cur_read  <= 1'b1;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                cur_space <= space_e'(req_space);
                cur_read  <= !(req_space && req_write);
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/mux_membus_drive.sv
module mux_membus_drive
    import mux_membus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              phase_end,
    input  space_e            cur_space,
    input  logic              cur_read,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic              req_ready,
    output logic              ale,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              prog_rd_n,
    output logic              data_rd_n,
    output logic              data_wr_n,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Moore output decode
    always_comb begin
        req_ready = 1'b0;
        ale       = 1'b0;
        addr_hi   = cur_addr[ADDR_W-1:DATA_W];
        ad_out    = '0;
        ad_oe     = 1'b0;
        prog_rd_n = 1'b1;
        data_rd_n = 1'b1;
        data_wr_n = 1'b1;
        rsp_done  = 1'b0;
        unique case (phase)
            ST_IDLE: begin
                req_ready = 1'b1;
                addr_hi   = '0;
            end
            ST_ADDR: begin
                ale    = !phase_end;
                ad_oe  = 1'b1;
                ad_out = cur_addr[DATA_W-1:0];
            end
            ST_FLOAT: begin
                ad_oe = 1'b0;
            end
            ST_STROBE: begin
                if (!cur_read) begin
                    data_wr_n = 1'b0;
                    ad_oe     = 1'b1;
                    ad_out    = cur_wdata;
                end else if (cur_space == SP_PROG) begin
                    prog_rd_n = 1'b0;
                end else begin
                    data_rd_n = 1'b0;
                end
            end
            ST_SAMPLE: begin
                rsp_done = 1'b1;
                if (!cur_read) begin
                    ad_oe  = 1'b1;
                    ad_out = cur_wdata;
                end
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    // read byte taken on the edge that closes the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if ((phase == ST_STROBE) && phase_end && cur_read) begin
            rsp_rdata <= ad_in;
        end
    end

endmodule

// File: rtl/mux_membus.sv
module mux_membus
    import mux_membus_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int ADDR_CYC = 2,
    parameter int STB_CYC  = 2,
    localparam int HI_W    = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_space,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [HI_W-1:0]   bus_addr_hi,
    output logic              bus_ale,
    output logic              bus_prog_rd_n,
    output logic              bus_data_rd_n,
    output logic              bus_data_wr_n
);

    if (ADDR_CYC < 2) begin : g_bad_addr_cyc
        $error("ADDR_CYC must be at least 2 so the latch pulse ends before data");
    end
    if (STB_CYC < 1) begin : g_bad_stb_cyc
        $error("STB_CYC must be at least 1");
    end

    phase_e            phase;
    logic              phase_end;
    space_e            cur_space;
    logic              cur_read;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    mux_membus_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ADDR_CYC(ADDR_CYC),
        .STB_CYC (STB_CYC)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_space(req_space),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .phase    (phase),
        .phase_end(phase_end),
        .cur_space(cur_space),
        .cur_read (cur_read),
        .cur_addr (cur_addr),
        .cur_wdata(cur_wdata)
    );

    mux_membus_drive #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .phase_end(phase_end),
        .cur_space(cur_space),
        .cur_read (cur_read),
        .cur_addr (cur_addr),
        .cur_wdata(cur_wdata),
        .ad_in    (bus_ad_in),
        .req_ready(req_ready),
        .ale      (bus_ale),
        .addr_hi  (bus_addr_hi),
        .ad_out   (bus_ad_out),
        .ad_oe    (bus_ad_oe),
        .prog_rd_n(bus_prog_rd_n),
        .data_rd_n(bus_data_rd_n),
        .data_wr_n(bus_data_wr_n),
        .rsp_done (rsp_done),
        .rsp_rdata(rsp_rdata)
    );

endmodule

// File: rtl/mux_membus_chk.sv
module mux_membus_chk #(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_done,
    input logic            bus_ad_oe,
    input logic [HI_W-1:0] bus_addr_hi,
    input logic            bus_ale,
    input logic            bus_prog_rd_n,
    input logic            bus_data_rd_n,
    input logic            bus_data_wr_n
);

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~bus_prog_rd_n, ~bus_data_rd_n, ~bus_data_wr_n}) <= 1);

    // R11
    ale_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_prog_rd_n && bus_data_rd_n && bus_data_wr_n));

    // R2
    ale_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> bus_ad_oe);

    // R2
    ale_fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ale) |-> bus_ad_oe);

    // R7
    read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_prog_rd_n || !bus_data_rd_n) |-> !bus_ad_oe);

    // R7
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_prog_rd_n) || $fell(bus_data_rd_n)) |-> $past(!bus_ad_oe));

    // R6
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_data_wr_n |-> bus_ad_oe);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R10
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    addr_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(bus_addr_hi));

endmodule

bind mux_membus mux_membus_chk #(.HI_W(HI_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_done     (rsp_done),
    .bus_ad_oe    (bus_ad_oe),
    .bus_addr_hi  (bus_addr_hi),
    .bus_ale      (bus_ale),
    .bus_prog_rd_n(bus_prog_rd_n),
    .bus_data_rd_n(bus_data_rd_n),
    .bus_data_wr_n(bus_data_wr_n)
);

// File: tb/test_mux_membus.sv
`timescale 1ns/1ps
module test_mux_membus;

    localparam int ADDR_CYC = 2;
    localparam int STB_CYC  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_space = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic [7:0]  bus_ad_in;
    logic [7:0]  bus_addr_hi;
    logic        bus_ale;
    logic        bus_prog_rd_n;
    logic        bus_data_rd_n;
    logic        bus_data_wr_n;

    always #2.5 clk = ~clk;

    mux_membus #(.ADDR_CYC(ADDR_CYC), .STB_CYC(STB_CYC)) i_mux_membus (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_space(req_space), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_addr_hi(bus_addr_hi), .bus_ale(bus_ale), .bus_prog_rd_n(bus_prog_rd_n),
        .bus_data_rd_n(bus_data_rd_n), .bus_data_wr_n(bus_data_wr_n)
    );

    typedef struct {
        logic        space;
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  wdata;
        int          due;
    } item_t;

    item_t      q[$];
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    logic [7:0] lat_lo = '0;
    logic [7:0] last_rd = '0;

    function automatic logic [7:0] memval(input logic space, input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ (space ? 8'h5A : 8'hC3);
    endfunction

    // external memory model: junk outside the read strobe
    assign bus_ad_in = !bus_prog_rd_n ? memval(1'b0, {bus_addr_hi, lat_lo}) :
                       !bus_data_rd_n ? memval(1'b1, {bus_addr_hi, lat_lo}) : 8'hEE;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // driver: pushes expected item, presents request for one accepted edge
    task automatic issue(input logic space, input logic wr,
                         input logic [15:0] a, input logic [7:0] wd);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_space = space;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        req_valid = 1'b1;
        it.space = space;
        it.wr    = space & wr;
        it.addr  = a;
        it.wdata = wd;
        it.due   = cyc + 1 + ADDR_CYC + STB_CYC + ((space & wr) ? 0 : 1);
        q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor
    int   ale_cnt = 0, stb_cnt = 0, float_cnt = 0;
    int   oe_bad = 0, wd_bad = 0, hold_bad = 0, overlap = 0;
    int   kind = 0;
    logic prev_ale = 1'b0, prev_done = 1'b0, in_acc = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            int lows;
            lows = int'(!bus_prog_rd_n) + int'(!bus_data_rd_n) + int'(!bus_data_wr_n);
            if (lows > 1 || (lows > 0 && bus_ale)) overlap++;
            if (prev_ale && !bus_ale && !(bus_ad_oe && bus_ad_out == lat_lo)) hold_bad++;
            if (bus_ale) begin
                ale_cnt++;
                lat_lo = bus_ad_out;
                in_acc = 1'b1;
                if (!bus_ad_oe) hold_bad++;
            end else if (in_acc && stb_cnt == 0 && lows == 0 && !bus_ad_oe) begin
                float_cnt++;
            end
            if (!bus_prog_rd_n) begin kind = 1; stb_cnt++; end
            if (!bus_data_rd_n) begin kind = 2; stb_cnt++; end
            if ((!bus_prog_rd_n || !bus_data_rd_n) && bus_ad_oe) oe_bad++;
            if (!bus_data_wr_n) begin
                kind = 3;
                stb_cnt++;
                if (q.size() == 0 || !bus_ad_oe || bus_ad_out != q[0].wdata) wd_bad++;
            end
            if (rsp_done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R10", "done with no request", 1, 0);
                end else begin
                    item_t e;
                    int    ek;
                    e  = q.pop_front();
                    ek = (e.space == 1'b0) ? 1 : (e.wr ? 3 : 2);
                    chk(!prev_done, "R9", "done not single pulse", 32'(prev_done), 0);
                    chk(cyc == e.due, "R9", "done cycle", cyc, e.due);
                    chk({bus_addr_hi, lat_lo} == e.addr, "R3", "latched address",
                        {bus_addr_hi, lat_lo}, e.addr);
                    chk(ale_cnt == ADDR_CYC - 1 && hold_bad == 0, "R2", "ale width/hold",
                        ale_cnt, ADDR_CYC - 1);
                    chk(kind == ek, ek == 1 ? "R4" : (ek == 2 ? "R5" : "R6"),
                        "strobe kind", kind, ek);
                    chk(stb_cnt == STB_CYC, ek == 1 ? "R4" : (ek == 2 ? "R5" : "R6"),
                        "strobe width", stb_cnt, STB_CYC);
                    if (ek == 3) begin
                        chk(wd_bad == 0 && bus_ad_oe && bus_ad_out == e.wdata, "R6",
                            "write data drive", bus_ad_out, e.wdata);
                        chk(rsp_rdata == last_rd, "R8", "rdata kept across write",
                            rsp_rdata, last_rd);
                    end else begin
                        chk(float_cnt >= 1 && oe_bad == 0, "R7", "port release before strobe",
                            float_cnt, 1);
                        chk(rsp_rdata == memval(e.space, e.addr), "R8", "read data",
                            rsp_rdata, memval(e.space, e.addr));
                        last_rd = memval(e.space, e.addr);
                    end
                end
                ale_cnt = 0; stb_cnt = 0; float_cnt = 0;
                oe_bad = 0; wd_bad = 0; hold_bad = 0; kind = 0; in_acc = 1'b0;
            end
            prev_ale  = bus_ale;
            prev_done = rsp_done;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(req_ready && !bus_ale && bus_prog_rd_n && bus_data_rd_n && bus_data_wr_n &&
            !bus_ad_oe && !rsp_done && bus_addr_hi == 0 && rsp_rdata == 0,
            "R1", "reset outputs", {bus_ale, bus_ad_oe, rsp_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_ale && !bus_ad_oe && bus_prog_rd_n && bus_addr_hi == 0,
            "R1", "outputs after reset", {req_ready, bus_ale, bus_ad_oe}, 3'b100);

        issue(1'b0, 1'b0, 16'h1234, 8'h00);   // R4 fetch
        issue(1'b0, 1'b1, 16'hFF00, 8'h77);   // R4 write flag ignored in program space
        issue(1'b1, 1'b0, 16'h00FF, 8'h00);   // R5 data read
        issue(1'b1, 1'b1, 16'hABCD, 8'h3C);   // R6 data write, R8 rdata kept
        issue(1'b1, 1'b0, 16'h0000, 8'h00);
        issue(1'b1, 1'b1, 16'hFFFF, 8'hA5);
        issue(1'b1, 1'b0, 16'h8001, 8'h00);   // back-to-back reads
        issue(1'b1, 1'b0, 16'h7FFE, 8'h00);
        issue(1'b0, 1'b0, 16'hFFFF, 8'h00);
        drain();

        // R10: request raised while busy is ignored
        issue(1'b1, 1'b0, 16'h4242, 8'h00);
        @(negedge clk);
        req_space = 1'b1; req_write = 1'b1; req_addr = 16'h9999; req_wdata = 8'h11;
        req_valid = 1'b1;
        chk(!req_ready, "R10", "ready low while busy", 32'(req_ready), 0);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        repeat (4) begin
            @(negedge clk);
            chk(req_ready && !bus_ale && bus_data_wr_n, "R10", "no stray access",
                {req_ready, bus_ale, bus_data_wr_n}, 3'b101);
        end

        chk(overlap == 0, "R11", "strobe overlap cycles", overlap, 0);
        chk(q.size() == 0, "R9", "outstanding accesses", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule